// File: doc/BRIEF.md
# Serial-Bus Interrupt Register Bank

This block holds the interrupt state of a serial-bus controller. Nine event sources send single-cycle pulses. Each pulse sets a sticky status bit, which stays set until software writes a 1 to that bit. A per-source mask decides which of those status bits reach the single interrupt line.

Software never writes the mask directly. It writes ones to an unmask register to let sources through, and ones to a separate mask-set register to block them. Both of those registers are write-only. The current mask can be read back through a read-only view. All four registers use the same bit positions for the same sources. Because clearing is write-one-to-clear, a handler can write back the status value it read and clear exactly the events it saw.

Top module: `irq_regbank`

## Requirements
- R1: After reset every status bit reads 0, the mask view (offset 0x20) reads 0x2FF (all sources masked) and `irq_o` is 0.
- R2: A 1 on bit b of `evt_i` for one cycle sets status bit b (status at offset 0x10), and the bit stays set after the pulse ends. Source bits are: 0 complete, 1 data, 2 NACK, 3 timeout, 4 slave ready, 5 RX overflow, 6 TX overflow, 7 RX underflow, 9 arbitration lost.
- R3: A write to the status offset clears exactly the status bits written as 1 and leaves every other bit unchanged. Writing back a value read from status therefore returns status to 0.
- R4: Writing to the unmask register (offset 0x24) clears the mask bits written as 1 and leaves every other mask bit unchanged.
- R5: Writing to the mask-set register (offset 0x28) sets the mask bits written as 1 and leaves every other mask bit unchanged.
- R6: `irq_o` is 1 in the same cycle that any status bit is 1 while its mask bit is 0, and 0 otherwise.
- R7: Bit 8 and bits 31:10 are reserved. They read 0 in every register, writes to them have no effect, and a pulse on `evt_i[8]` has no effect.
- R8: If an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Reads of the unmask and mask-set offsets, and of any unmapped offset, return 0. Writes to the mask view offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset for the read or write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_i | input | 10 | Event pulses, one bit per source position |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default values: 10 source positions, 32-bit data and the 0x2FF live-bit map. Ten positions give only 1024 patterns, so the bench can sweep every pattern. Every value of the clear write is applied to a fully set status register. Every unmask pattern is combined with a fixed mask-set pattern, and in each case the interrupt line is checked against the OR of the unmasked bits. Each event bit, including reserved bit 8, is also pulsed on its own, and a pulse is made to collide with a clear on the same bit.

// File: rtl/irq_regbank.sv
module irq_regbank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NSRC = 10,
  parameter logic [NSRC-1:0] LIVE = 10'h2FF,
  parameter logic [ADDR_W-1:0] A_STAT = 8'h10,
  parameter logic [ADDR_W-1:0] A_MASK = 8'h20,
  parameter logic [ADDR_W-1:0] A_EN = 8'h24,
  parameter logic [ADDR_W-1:0] A_DIS = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   evt_i,
  output logic              irq_o
);

  logic [NSRC-1:0] status_q, mask_q;
  logic [NSRC-1:0] wsrc, evt_live, clr;
  logic hit_stat, hit_en, hit_dis;

  assign wsrc     = bus_wdata[NSRC-1:0] & LIVE;
  assign evt_live = evt_i & LIVE;
  assign hit_stat = bus_wr && (bus_addr == A_STAT);
  assign hit_en   = bus_wr && (bus_addr == A_EN);
  assign hit_dis  = bus_wr && (bus_addr == A_DIS);
  assign clr      = hit_stat ? wsrc : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= LIVE;
    end else begin
      status_q <= (status_q & ~clr) | evt_live;
      if (hit_en)
        mask_q <= mask_q & ~wsrc;
      else if (hit_dis)
        mask_q <= mask_q | wsrc;
    end
  end

  assign irq_o = |(status_q & ~mask_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT)
      bus_rdata[NSRC-1:0] = status_q;
    else if (bus_addr == A_MASK)
      bus_rdata[NSRC-1:0] = mask_q;
  end

  // R2: a set status bit survives any cycle without a clear write
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R8: a pulse always lands, even against a clear of the same bit
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_live) |=> ((status_q & $past(evt_live)) == $past(evt_live)));

  // R4
  p_unmask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_en |=> ((mask_q & $past(wsrc)) == '0));

  // R5
  p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_dis |=> ((mask_q & $past(wsrc)) == $past(wsrc)));

  // R6: everything masked means no request
  p_quiet_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == LIVE) |-> !irq_o);

  // R7
  p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q | mask_q) & ~LIVE) == '0);

endmodule

// File: tb/test_irq_regbank.sv
module test_irq_regbank;
  localparam logic [9:0] LIVE = 10'h2FF;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [9:0]  evt_i = 0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  irq_regbank i_irq_regbank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic pulse(logic [9:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d, output logic irq);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
    irq = irq_o;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic irq;
    logic [31:0] exp_mask;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(8'h10, d, irq); check("R1 status", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rd(8'h20, d, irq); check("R1 mask", d, 32'h2FF);

    for (int b = 0; b < 10; b++) begin
      pulse(10'(1 << b));
      @(negedge clk);
      rd(8'h10, d, irq);
      check(b == 8 ? "R7 event bit 8" : "R2 sticky", d, 32'(LIVE & 10'(1 << b)));
      check("R6 masked irq", {31'b0, irq}, 0);
      wr(8'h10, 32'hFFFF_FFFF);
      rd(8'h10, d, irq); check("R3 clear all", d, 0);
    end

    for (int v = 0; v < 1024; v++) begin
      pulse(10'h3FF);
      wr(8'h10, 32'hFFFF_FC00 | 32'(v));
      rd(8'h10, d, irq);
      check("R3 w1c sweep", d, 32'(LIVE & ~10'(v)));
      wr(8'h10, d);
      rd(8'h10, d, irq); check("R3 write-back", d, 0);
    end

    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h10; bus_wdata = 32'h4; evt_i = 10'h4;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0; evt_i = 0;
    rd(8'h10, d, irq); check("R8 set wins", d, 32'h4);
    wr(8'h10, 32'h4);

    for (int v = 0; v < 1024; v++) begin
      pulse(10'h3FF);
      wr(8'h28, 32'hFFFF_FFFF);
      wr(8'h24, 32'hFFFF_FC00 | 32'(v));
      rd(8'h20, d, irq);
      exp_mask = 32'(LIVE & ~10'(v));
      check("R4 unmask", d, exp_mask);
      check("R6 irq", {31'b0, irq}, {31'b0, |(LIVE & 10'(v))});
      wr(8'h20, 32'h0);
      rd(8'h20, d, irq); check("R9 mask view read-only", d, exp_mask);
      wr(8'h28, 32'hFFFF_FD55);
      rd(8'h20, d, irq);
      check("R5 mask set", d, exp_mask | 32'(LIVE & 10'h155));
      check("R6 irq after mask set", {31'b0, irq},
            {31'b0, |(LIVE & 10'(v) & ~10'h155)});
    end

    rd(8'h24, d, irq); check("R9 unmask reads 0", d, 0);
    rd(8'h28, d, irq); check("R9 mask-set reads 0", d, 0);
    rd(8'h04, d, irq); check("R9 unmapped", d, 0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d, irq); check("R6 irq no status", {31'b0, irq}, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule